// File: doc/BRIEF.md
# Gate-Steered Bus Datapath

This block is a small byte-wide datapath built around one shared bus. Data is not addressed by operand fields. Each 4-bit opcode either flips one routing gate between the bus and a destination, or fires a source that puts a value on the bus for one cycle. Any value that reaches the bus is taken by every destination whose gate was open during that cycle.

The destinations are:
- two input buffers on an AND unit and two on an XOR unit;
- an accumulating OR unit;
- two general registers;
- an output buffer that feeds the pins.

The sources are:
- the three logic results;
- the two registers;
- a buffer that captures the input pins on a strobe;
- a literal value driven by the external sequencer.

A program moves data by opening the gates on a path, firing a source, and then closing the gates again. The output pins change only at the moment the output gate is closed.

Top module: `gsb_datapath`

## Requirements
- R1: After reset, all eight gates are closed; every buffer, the OR accumulator, both registers and `pin_out` hold zero.
- R2: The bus source for a cycle is chosen as follows.
  - When `lit_valid` is high, the bus carries `lit_data`. This has priority over any opcode-driven source.
  - Otherwise, a valid opcode drives the bus as follows: 0 the OR accumulator, 1 the input-pin buffer, 2 the AND result, 7 the XOR result, 14 register 1, 15 register 2.
  - Any other opcode leaves the bus undriven.
- R3: In a cycle where the bus is driven, every destination whose gate was open takes the bus value. In a cycle where the bus is undriven, no destination is written.
- R4: AND and XOR unit behaviour.
  - Opcodes 4 and 3 toggle the gates of AND buffer A and AND buffer B. Opcodes 9 and 8 toggle the gates of XOR buffer A and XOR buffer B.
  - Opcode 2 drives A AND B; opcode 7 drives A XOR B.
  - Each of these two compute opcodes clears both buffers of its own unit. The clear wins over a latch of the bus in that cycle.
- R5: Opcode 6 toggles the OR gate. While the OR gate is open, the accumulator ORs in every driven bus value. Opcode 0 drives the accumulator and clears it, and the clear wins.
- R6: Input-pin buffer behaviour.
  - A high `pin_strobe` captures `pin_in` into the input-pin buffer.
  - Opcode 1 drives that buffer and then clears it.
  - When a strobe and opcode 1 occur in the same cycle, the old value is driven and the new capture is kept.
- R7: Register behaviour.
  - Opcodes 10 and 11 toggle the write gates of register 1 and register 2.
  - Opcode 13 clears register 1 and opcode 12 clears register 2. A clear wins over a write in the same cycle.
- R8: Output behaviour.
  - Opcode 5 toggles the output gate.
  - When that opcode closes the gate, `pin_out` takes the output buffer's value, including a value latched in that same cycle.
  - At all other times `pin_out` holds its value, even while the buffer changes.
- R9: An opcode with `op_valid` low has no effect on any gate, buffer or register.
- R10: Whether a destination latches depends on its gate state at the start of the cycle. A gate toggled in a cycle affects the following cycles only. At most one gate changes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode present this cycle |
| op_code | input | 4 | Gate-toggle or action opcode |
| lit_valid | input | 1 | Sequencer drives a literal onto the bus |
| lit_data | input | DATA_W | Literal value |
| pin_strobe | input | 1 | Capture `pin_in` into the input-pin buffer |
| pin_in | input | DATA_W | Input pins |
| pin_out | output | DATA_W | Output pins, updated when the output gate closes |

## Verification
The only observable port is `pin_out`, so a fault inside the block stays hidden until a path routes the faulty value to the output buffer and the output gate is closed.

A wrong gate state or a missed clear appears three cycles later, through a sequence of open-output, fire-source and close-output. It shows up as a byte that differs from the value the bench predicts.

A gate toggled in the wrong cycle, or a clear that loses to a latch, changes the contents of a register or buffer. That error then persists in every later read-out of the same storage, until it is cleared.

// File: rtl/gsb_pkg.sv
package gsb_pkg;

   localparam int OP_W    = 4;
   localparam int N_GATES = 8;

   typedef enum logic [OP_W-1:0] {
      OP_OR_FIRE   = 4'd0,
      OP_PIN_FIRE  = 4'd1,
      OP_AND_FIRE  = 4'd2,
      OP_AND_GB    = 4'd3,
      OP_AND_GA    = 4'd4,
      OP_OUT_G     = 4'd5,
      OP_OR_G      = 4'd6,
      OP_XOR_FIRE  = 4'd7,
      OP_XOR_GB    = 4'd8,
      OP_XOR_GA    = 4'd9,
      OP_R1_G      = 4'd10,
      OP_R2_G      = 4'd11,
      OP_R2_CLR    = 4'd12,
      OP_R1_CLR    = 4'd13,
      OP_R1_FIRE   = 4'd14,
      OP_R2_FIRE   = 4'd15
   } gsb_op_e;

   // gate positions inside the gate vector
   localparam int G_AND_A = 0;
   localparam int G_AND_B = 1;
   localparam int G_XOR_A = 2;
   localparam int G_XOR_B = 3;
   localparam int G_OR    = 4;
   localparam int G_R1    = 5;
   localparam int G_R2    = 6;
   localparam int G_OUT   = 7;

   // logic unit flavours
   localparam int KIND_AND = 0;
   localparam int KIND_XOR = 1;

endpackage

// File: rtl/gsb_gate_bank.sv
module gsb_gate_bank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] toggle,
   output logic [N-1:0] gate_q
);

   if (N < 1) begin : g_bad_n
      $error("gsb_gate_bank: N must be at least 1");
   end

   for (genvar gi = 0; gi < N; gi++) begin : g_gate
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          gate_q[gi] <= 1'b0;
         else if (toggle[gi]) gate_q[gi] <= ~gate_q[gi];
      end
   end

endmodule

// File: rtl/gsb_hold_reg.sv
module gsb_hold_reg #(
   parameter int W        = 8,
   parameter bit CLR_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("gsb_hold_reg: W must be at least 1");
   end

   logic [W-1:0] q_nxt;

   if (CLR_WINS) begin : g_clr_first
      always_comb begin
         q_nxt = q;
         if (clr)       q_nxt = '0;
         else if (load) q_nxt = d;
      end
   end else begin : g_load_first
      always_comb begin
         q_nxt = q;
         if (load)      q_nxt = d;
         else if (clr)  q_nxt = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end

endmodule

// File: rtl/gsb_logic_pair.sv
module gsb_logic_pair #(
   parameter int W    = 8,
   parameter int KIND = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bus_drv,
   input  logic [W-1:0] bus_val,
   input  logic         gate_a,
   input  logic         gate_b,
   input  logic         fire,
   output logic [W-1:0] result,
   output logic [W-1:0] buf_a,
   output logic [W-1:0] buf_b
);

   if (KIND != gsb_pkg::KIND_AND && KIND != gsb_pkg::KIND_XOR) begin : g_bad_kind
      $error("gsb_logic_pair: KIND selects an unknown function");
   end

   gsb_hold_reg #(.W(W), .CLR_WINS(1'b1)) u_a (
      .clk(clk), .rst_n(rst_n), .clr(fire),
      .load(bus_drv & gate_a), .d(bus_val), .q(buf_a));

   gsb_hold_reg #(.W(W), .CLR_WINS(1'b1)) u_b (
      .clk(clk), .rst_n(rst_n), .clr(fire),
      .load(bus_drv & gate_b), .d(bus_val), .q(buf_b));

   if (KIND == gsb_pkg::KIND_XOR) begin : g_xor
      assign result = buf_a ^ buf_b;
   end else begin : g_and
      assign result = buf_a & buf_b;
   end

endmodule

// File: rtl/gsb_or_acc.sv
module gsb_or_acc #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bus_drv,
   input  logic [W-1:0] bus_val,
   input  logic         gate,
   input  logic         fire,
   output logic [W-1:0] acc
);

   if (W < 1) begin : g_bad_w
      $error("gsb_or_acc: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                acc <= '0;
      else if (fire)             acc <= '0;
      else if (bus_drv && gate)  acc <= acc | bus_val;
   end

endmodule

// File: rtl/gsb_datapath.sv
module gsb_datapath #(
   parameter int DATA_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    op_valid,
   input  logic [gsb_pkg::OP_W-1:0] op_code,
   input  logic                    lit_valid,
   input  logic [DATA_W-1:0]       lit_data,
   input  logic                    pin_strobe,
   input  logic [DATA_W-1:0]       pin_in,
   output logic [DATA_W-1:0]       pin_out
);
   import gsb_pkg::*;

   if (DATA_W < 1) begin : g_bad_w
      $error("gsb_datapath: DATA_W must be at least 1");
   end

   logic [N_GATES-1:0] toggle, gate_q;
   logic               fire_or, fire_and, fire_xor, fire_pin;
   logic               clr_r1, clr_r2;
   logic               bus_drv;
   logic [DATA_W-1:0]  bus_val;
   logic [DATA_W-1:0]  or_acc, and_res, xor_res;
   logic [DATA_W-1:0]  and_a, and_b, xor_a, xor_b;
   logic [DATA_W-1:0]  reg1_q, reg2_q, inbuf_q, out_buf_q;
   logic               out_close;
   gsb_op_e            op;

   assign op = gsb_op_e'(op_code);

   // opcode decode
   always_comb begin
      toggle   = '0;
      fire_or  = 1'b0;
      fire_and = 1'b0;
      fire_xor = 1'b0;
      fire_pin = 1'b0;
      clr_r1   = 1'b0;
      clr_r2   = 1'b0;
      if (op_valid) begin
         unique case (op)
            OP_OR_FIRE:  fire_or  = 1'b1;
            OP_PIN_FIRE: fire_pin = 1'b1;
            OP_AND_FIRE: fire_and = 1'b1;
            OP_AND_GB:   toggle[G_AND_B] = 1'b1;
            OP_AND_GA:   toggle[G_AND_A] = 1'b1;
            OP_OUT_G:    toggle[G_OUT]   = 1'b1;
            OP_OR_G:     toggle[G_OR]    = 1'b1;
            OP_XOR_FIRE: fire_xor = 1'b1;
            OP_XOR_GB:   toggle[G_XOR_B] = 1'b1;
            OP_XOR_GA:   toggle[G_XOR_A] = 1'b1;
            OP_R1_G:     toggle[G_R1]    = 1'b1;
            OP_R2_G:     toggle[G_R2]    = 1'b1;
            OP_R2_CLR:   clr_r2   = 1'b1;
            OP_R1_CLR:   clr_r1   = 1'b1;
            default:     ;
         endcase
      end
   end

   // bus source selection, literal first
   always_comb begin
      bus_drv = 1'b0;
      bus_val = '0;
      if (lit_valid) begin
         bus_drv = 1'b1;
         bus_val = lit_data;
      end else if (op_valid) begin
         bus_drv = 1'b1;
         case (op)
            OP_OR_FIRE:  bus_val = or_acc;
            OP_PIN_FIRE: bus_val = inbuf_q;
            OP_AND_FIRE: bus_val = and_res;
            OP_XOR_FIRE: bus_val = xor_res;
            OP_R1_FIRE:  bus_val = reg1_q;
            OP_R2_FIRE:  bus_val = reg2_q;
            default:     bus_drv = 1'b0;
         endcase
      end
   end

   gsb_gate_bank #(.N(N_GATES)) u_gates (
      .clk(clk), .rst_n(rst_n), .toggle(toggle), .gate_q(gate_q));

   gsb_logic_pair #(.W(DATA_W), .KIND(KIND_AND)) u_and (
      .clk(clk), .rst_n(rst_n), .bus_drv(bus_drv), .bus_val(bus_val),
      .gate_a(gate_q[G_AND_A]), .gate_b(gate_q[G_AND_B]), .fire(fire_and),
      .result(and_res), .buf_a(and_a), .buf_b(and_b));

   gsb_logic_pair #(.W(DATA_W), .KIND(KIND_XOR)) u_xor (
      .clk(clk), .rst_n(rst_n), .bus_drv(bus_drv), .bus_val(bus_val),
      .gate_a(gate_q[G_XOR_A]), .gate_b(gate_q[G_XOR_B]), .fire(fire_xor),
      .result(xor_res), .buf_a(xor_a), .buf_b(xor_b));

   gsb_or_acc #(.W(DATA_W)) u_or (
      .clk(clk), .rst_n(rst_n), .bus_drv(bus_drv), .bus_val(bus_val),
      .gate(gate_q[G_OR]), .fire(fire_or), .acc(or_acc));

   gsb_hold_reg #(.W(DATA_W), .CLR_WINS(1'b1)) u_reg1 (
      .clk(clk), .rst_n(rst_n), .clr(clr_r1),
      .load(bus_drv & gate_q[G_R1]), .d(bus_val), .q(reg1_q));

   gsb_hold_reg #(.W(DATA_W), .CLR_WINS(1'b1)) u_reg2 (
      .clk(clk), .rst_n(rst_n), .clr(clr_r2),
      .load(bus_drv & gate_q[G_R2]), .d(bus_val), .q(reg2_q));

   // strobe capture beats the read-clear
   gsb_hold_reg #(.W(DATA_W), .CLR_WINS(1'b0)) u_inbuf (
      .clk(clk), .rst_n(rst_n), .clr(fire_pin),
      .load(pin_strobe), .d(pin_in), .q(inbuf_q));

   gsb_hold_reg #(.W(DATA_W), .CLR_WINS(1'b1)) u_outbuf (
      .clk(clk), .rst_n(rst_n), .clr(1'b0),
      .load(bus_drv & gate_q[G_OUT]), .d(bus_val), .q(out_buf_q));

   // release on close, carrying a value latched in the closing cycle
   assign out_close = toggle[G_OUT] & gate_q[G_OUT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pin_out <= '0;
      else if (out_close) pin_out <= (bus_drv ? bus_val : out_buf_q);
   end

endmodule

module gsb_datapath_chk #(
   parameter int W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     op_valid,
   input logic [gsb_pkg::OP_W-1:0] op_code,
   input logic                     pin_strobe,
   input logic [W-1:0]             pin_in,
   input logic [W-1:0]             pin_out,
   input logic [gsb_pkg::N_GATES-1:0] gate_q,
   input logic [W-1:0]             out_buf_q,
   input logic [W-1:0]             and_a,
   input logic [W-1:0]             and_b,
   input logic [W-1:0]             reg1_q,
   input logic [W-1:0]             inbuf_q
);
   import gsb_pkg::*;

   logic closing;
   assign closing = op_valid && (op_code == OP_OUT_G) && gate_q[G_OUT];

   AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (gate_q == '0) && (pin_out == '0)); // R1
   AST_AND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_AND_FIRE) |=> (and_a == '0) && (and_b == '0)); // R4
   AST_PIN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      pin_strobe |=> inbuf_q == $past(pin_in)); // R6
   AST_PIN_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_PIN_FIRE && !pin_strobe) |=> inbuf_q == '0); // R6
   AST_REG1_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_R1_CLR) |=> reg1_q == '0); // R7
   AST_RELEASE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      closing |=> pin_out == out_buf_q); // R8
   AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !closing |=> $stable(pin_out)); // R8
   AST_IDLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(gate_q)); // R9
   AST_ONE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> $countones(gate_q ^ $past(gate_q)) <= 1); // R10

endmodule

bind gsb_datapath gsb_datapath_chk #(.W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
   .pin_strobe(pin_strobe), .pin_in(pin_in), .pin_out(pin_out),
   .gate_q(gate_q), .out_buf_q(out_buf_q), .and_a(and_a), .and_b(and_b),
   .reg1_q(reg1_q), .inbuf_q(inbuf_q));

// File: tb/gsb_datapath_bench.sv
`timescale 1ns/1ps
module gsb_datapath_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       op_valid;
   logic [3:0] op_code;
   logic       lit_valid;
   logic [7:0] lit_data;
   logic       pin_strobe;
   logic [7:0] pin_in;
   logic [7:0] pin_out;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   gsb_datapath #(.DATA_W(8)) u_gsb_datapath (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .lit_valid(lit_valid), .lit_data(lit_data), .pin_strobe(pin_strobe),
      .pin_in(pin_in), .pin_out(pin_out));

   task automatic cyc(input logic v, input logic [3:0] c, input logic lv,
                      input logic [7:0] l, input logic s, input logic [7:0] p);
      op_valid = v; op_code = c; lit_valid = lv; lit_data = l;
      pin_strobe = s; pin_in = p;
      @(negedge clk);
      op_valid = 1'b0; lit_valid = 1'b0; pin_strobe = 1'b0;
   endtask

   task automatic op(input logic [3:0] c);
      cyc(1'b1, c, 1'b0, 8'h00, 1'b0, 8'h00);
   endtask

   task automatic lit(input logic [7:0] x);
      cyc(1'b0, 4'd0, 1'b1, x, 1'b0, 8'h00);
   endtask

   // route one opcode-driven source to the pins
   task automatic show(input logic [3:0] c);
      op(4'd5); op(c); op(4'd5);
   endtask

   task automatic chk(input string req, input logic [7:0] exp);
      n_tests++;
      if (pin_out !== exp) begin
         n_fail++;
         $display("FAIL %s pin_out=%h expected=%h", req, pin_out, exp);
      end
   endtask

   task automatic t_reset;
      chk("R1 pins after reset", 8'h00);
      show(4'd14); chk("R1 reg1 zero", 8'h00);
      show(4'd7);  chk("R1 xor buffers zero", 8'h00);
   endtask

   task automatic t_literal_out;
      op(4'd5); lit(8'hA5); op(4'd5);
      chk("R2 literal to pins", 8'hA5);
      op(4'd5); lit(8'h3B);
      chk("R8 pins hold while gate open", 8'hA5);
      op(4'd5);
      chk("R8 release on close", 8'h3B);
      op(4'd5); cyc(1'b1, 4'd5, 1'b1, 8'h7E, 1'b0, 8'h00);
      chk("R8 same-cycle latch released", 8'h7E);
      repeat (3) cyc(1'b0, 4'd0, 1'b0, 8'h00, 1'b0, 8'h00);
      chk("R8 pins hold when idle", 8'h7E);
   endtask

   task automatic t_registers;
      op(4'd10); lit(8'h3C); op(4'd10); lit(8'hFF);
      show(4'd14); chk("R7 reg1 written then gate closed", 8'h3C);
      op(4'd10); op(4'd12); op(4'd10);
      show(4'd14); chk("R3 undriven bus leaves reg1", 8'h3C);
      cyc(1'b1, 4'd11, 1'b1, 8'h55, 1'b0, 8'h00); op(4'd11);
      show(4'd15); chk("R10 opening cycle does not latch", 8'h00);
      op(4'd11); lit(8'h99); op(4'd11);
      show(4'd15); chk("R7 reg2 written", 8'h99);
      op(4'd11); cyc(1'b1, 4'd12, 1'b1, 8'h44, 1'b0, 8'h00); op(4'd11);
      show(4'd15); chk("R7 clear wins over write", 8'h00);
      op(4'd13);
      show(4'd14); chk("R7 reg1 cleared", 8'h00);
      cyc(1'b1, 4'd10, 1'b1, 8'h55, 1'b0, 8'h00);
      cyc(1'b1, 4'd10, 1'b1, 8'hAA, 1'b0, 8'h00);
      show(4'd14); chk("R10 closing cycle still latches", 8'hAA);
   endtask

   task automatic t_and;
      op(4'd4); lit(8'hF0); op(4'd4);
      op(4'd3); lit(8'h3C); op(4'd3);
      show(4'd2); chk("R4 and result", 8'h30);
      show(4'd2); chk("R4 and buffers cleared", 8'h00);
   endtask

   task automatic t_xor;
      op(4'd9); lit(8'h0F); op(4'd9);
      op(4'd8); lit(8'hFF); op(4'd8);
      show(4'd7); chk("R4 xor result", 8'hF0);
      op(4'd9); lit(8'h11); op(4'd7); op(4'd9);
      show(4'd7); chk("R4 xor clear wins over latch", 8'h00);
   endtask

   task automatic t_or;
      op(4'd6); lit(8'h01); lit(8'h80); lit(8'h10); op(4'd6);
      show(4'd0); chk("R5 or accumulate", 8'h91);
      show(4'd0); chk("R5 or cleared after fire", 8'h00);
   endtask

   task automatic t_pins_in;
      cyc(1'b0, 4'd0, 1'b0, 8'h00, 1'b1, 8'h5A);
      show(4'd1); chk("R6 capture and read", 8'h5A);
      show(4'd1); chk("R6 read clears", 8'h00);
      cyc(1'b0, 4'd0, 1'b0, 8'h00, 1'b1, 8'h22);
      op(4'd5); cyc(1'b1, 4'd1, 1'b0, 8'h00, 1'b1, 8'h77); op(4'd5);
      chk("R6 old value read on strobe", 8'h22);
      show(4'd1); chk("R6 new capture kept", 8'h77);
   endtask

   task automatic t_invalid;
      op(4'd10); lit(8'h6E); op(4'd10);
      cyc(1'b0, 4'd13, 1'b0, 8'h00, 1'b0, 8'h00);
      cyc(1'b0, 4'd10, 1'b0, 8'h00, 1'b0, 8'h00);
      lit(8'h11);
      show(4'd14); chk("R9 invalid opcodes ignored", 8'h6E);
   endtask

   task automatic t_priority;
      op(4'd5); cyc(1'b1, 4'd14, 1'b1, 8'hC3, 1'b0, 8'h00); op(4'd5);
      chk("R2 literal beats register source", 8'hC3);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; op_valid = 1'b0; op_code = 4'd0; lit_valid = 1'b0;
      lit_data = 8'h00; pin_strobe = 1'b0; pin_in = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_literal_out();
      t_registers();
      t_and();
      t_xor();
      t_or();
      t_pins_in();
      t_invalid();
      t_priority();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule